// File: doc/BRIEF.md
# GPIO Bank with Event Detection and Dual Interrupt Lines

This block is a bank of general-purpose I/O pins behind a small memory-mapped register port. Software sets the direction of each pin, drives an output latch, and reads back the synchronized pin levels. The output latch can be written whole, or changed bit by bit through separate set and clear addresses. Those two addresses let independent agents touch different pins without a read-modify-write.

Each pin can watch for four kinds of event: level low, level high, rising edge and falling edge. Any mix of the four is allowed, so setting both edge masks catches every transition. One event vector feeds two independent interrupt lines. Each line keeps its own sticky raw status, its own enable set, and its own interrupt output. One line can therefore serve one processor and the other line a second processor. Clearing a status bit on one line leaves the other line untouched.

The bus port works on single cycles. A valid, a write flag, a 12-bit byte address and 32-bit write data arrive together and take effect on the next clock edge. Read data is returned combinationally in the same cycle.

Top module: `gpio_evt_bank`

## Requirements
- R1: After reset the output latch, all four detect masks, both enable sets, both raw status registers and both interrupt outputs are 0, and every bit of the direction register is 1.
- R2: Offset 0x134 is the direction register, readable and writable. A 1 in bit n makes pin n an input (pin_drive_n[n]=1); a 0 makes the bank drive pin n.
- R3: Offset 0x13C reads and writes the output latch, which drives pin_out. A write to 0x194 sets every latch bit that is written as 1. A write to 0x190 clears every latch bit that is written as 1. Latch bits written as 0 through either address do not change.
- R4: Offset 0x138 returns the pin levels after a two-stage synchronizer. A level driven on pin_in before a clock edge is readable after the second rising edge that follows.
- R5: The level-low mask (0x140) and the level-high mask (0x144) are read/write. While an enabled level is present on a synchronized pin, the raw status bit of that pin stays set on both lines, even across a clear.
- R6: The rising mask (0x148) and the falling mask (0x14C) are read/write. A synchronized transition in an enabled direction sets the raw status bit once per edge. Setting both masks for a pin detects both edges.
- R7: Raw status (0x024 for line 0, 0x028 for line 1) records detected events whatever the enables are. A bit stays set until it is cleared.
- R8: Masked status (0x02C line 0, 0x030 line 1) reads raw status ANDed with that line's enables. Writing a 1 to a bit there clears that raw bit on that line only. Writing a 0 has no effect. An event in the same cycle wins over the clear.
- R9: Enable-set (0x034 line 0, 0x038 line 1) ORs the written ones into the line's enables. Enable-clear (0x03C line 0, 0x040 line 1) removes them. Zero bits have no effect, and both addresses of a line read back its enables.
- R10: irq_out[k] is 1 exactly when some pin has both its raw status and its enable set on line k, one cycle after the register update.
- R11: Offset 0x000 reads the constant 0x50600801 and ignores writes. Reads of unmapped offsets, of 0x190 and of 0x194 return 0, and bus_rdata is 0 in any cycle that is not a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus access in this cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| pin_in | input | 32 | Pad input levels, asynchronous |
| pin_out | output | 32 | Output latch to the pads |
| pin_drive_n | output | 32 | Per-pin active-low output enable |
| irq_out | output | 2 | Interrupt request per line |

## Verification
The assertions assume that the reset is applied before the first clock. They also assume that one bus access targets exactly one register, so that a set and a clear of the same register never fall in the same cycle. They do not assume that pin_in is synchronous. The bench changes pin_in and the bus signals only on falling edges and keeps to one access per cycle. Long random runs mix every mapped offset, some unmapped ones, and pin toggling. A behavioural model in the bench predicts all outputs on every cycle.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

   localparam int unsigned GE_ADDR_W    = 12;
   localparam int unsigned GE_DATA_W    = 32;
   localparam int unsigned GE_MAX_LINES = 2;
   localparam logic [31:0] GE_REVISION  = 32'h5060_0801;

   localparam logic [11:0] OFS_REV     = 12'h000;
   localparam logic [11:0] OFS_RAW0    = 12'h024;
   localparam logic [11:0] OFS_RAW1    = 12'h028;
   localparam logic [11:0] OFS_STAT0   = 12'h02C;
   localparam logic [11:0] OFS_STAT1   = 12'h030;
   localparam logic [11:0] OFS_ENSET0  = 12'h034;
   localparam logic [11:0] OFS_ENSET1  = 12'h038;
   localparam logic [11:0] OFS_ENCLR0  = 12'h03C;
   localparam logic [11:0] OFS_ENCLR1  = 12'h040;
   localparam logic [11:0] OFS_DIR     = 12'h134;
   localparam logic [11:0] OFS_DIN     = 12'h138;
   localparam logic [11:0] OFS_DOUT    = 12'h13C;
   localparam logic [11:0] OFS_MLO     = 12'h140;
   localparam logic [11:0] OFS_MHI     = 12'h144;
   localparam logic [11:0] OFS_MRISE   = 12'h148;
   localparam logic [11:0] OFS_MFALL   = 12'h14C;
   localparam logic [11:0] OFS_OCLR    = 12'h190;
   localparam logic [11:0] OFS_OSET    = 12'h194;

   typedef enum logic [3:0] {
      SEL_NONE, SEL_REV, SEL_RAW, SEL_STAT, SEL_ENSET, SEL_ENCLR,
      SEL_DIR, SEL_DIN, SEL_DOUT, SEL_MLO, SEL_MHI, SEL_MRISE,
      SEL_MFALL, SEL_OCLR, SEL_OSET
   } reg_sel_e;

   typedef struct packed {
      reg_sel_e sel;
      logic     line;
   } reg_dec_t;

   function automatic reg_dec_t ge_decode(input logic [GE_ADDR_W-1:0] a);
      reg_dec_t d;
      d.sel  = SEL_NONE;
      d.line = 1'b0;
      case (a)
         OFS_REV:    d.sel = SEL_REV;
         OFS_RAW0:   d.sel = SEL_RAW;
         OFS_RAW1:   begin d.sel = SEL_RAW;   d.line = 1'b1; end
         OFS_STAT0:  d.sel = SEL_STAT;
         OFS_STAT1:  begin d.sel = SEL_STAT;  d.line = 1'b1; end
         OFS_ENSET0: d.sel = SEL_ENSET;
         OFS_ENSET1: begin d.sel = SEL_ENSET; d.line = 1'b1; end
         OFS_ENCLR0: d.sel = SEL_ENCLR;
         OFS_ENCLR1: begin d.sel = SEL_ENCLR; d.line = 1'b1; end
         OFS_DIR:    d.sel = SEL_DIR;
         OFS_DIN:    d.sel = SEL_DIN;
         OFS_DOUT:   d.sel = SEL_DOUT;
         OFS_MLO:    d.sel = SEL_MLO;
         OFS_MHI:    d.sel = SEL_MHI;
         OFS_MRISE:  d.sel = SEL_MRISE;
         OFS_MFALL:  d.sel = SEL_MFALL;
         OFS_OCLR:   d.sel = SEL_OCLR;
         OFS_OSET:   d.sel = SEL_OSET;
         default:    d.sel = SEL_NONE;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/gpio_evt_sampler.sv
module gpio_evt_sampler #(
   parameter int unsigned NUM_PINS    = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_in,
   input  logic [NUM_PINS-1:0] mask_lo,
   input  logic [NUM_PINS-1:0] mask_hi,
   input  logic [NUM_PINS-1:0] mask_rise,
   input  logic [NUM_PINS-1:0] mask_fall,
   output logic [NUM_PINS-1:0] level_q,
   output logic [NUM_PINS-1:0] event_vec
);

   localparam int unsigned LAST = SYNC_STAGES - 1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_stages
         $error("gpio_evt_sampler: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [NUM_PINS-1:0] stage_q [SYNC_STAGES];
   logic [NUM_PINS-1:0] prev_q;
   logic [NUM_PINS-1:0] rise_raw;
   logic [NUM_PINS-1:0] fall_raw;

   generate
      for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= pin_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign level_q = stage_q[LAST];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= level_q;
   end

   assign rise_raw  = level_q & ~prev_q;
   assign fall_raw  = ~level_q & prev_q;
   assign event_vec = (~level_q & mask_lo) | (level_q & mask_hi) |
                      (rise_raw & mask_rise) | (fall_raw & mask_fall);

   // R6: an unmasked edge strobe never lasts two cycles on the same pin
   p_edge_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((rise_raw & $past(rise_raw)) == '0 && (fall_raw & $past(fall_raw)) == '0));

endmodule

// File: rtl/gpio_evt_line.sv
module gpio_evt_line #(
   parameter int unsigned NUM_PINS = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] event_vec,
   input  logic                en_set_we,
   input  logic                en_clr_we,
   input  logic                stat_clr_we,
   input  logic [NUM_PINS-1:0] wdata,
   output logic [NUM_PINS-1:0] raw_q,
   output logic [NUM_PINS-1:0] en_q,
   output logic                irq
);

   logic [NUM_PINS-1:0] clr_bits;

   assign clr_bits = stat_clr_we ? wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) raw_q <= '0;
      else        raw_q <= (raw_q & ~clr_bits) | event_vec;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         en_q <= '0;
      else if (en_set_we) en_q <= en_q | wdata;
      else if (en_clr_we) en_q <= en_q & ~wdata;
   end

   assign irq = |(raw_q & en_q);

   // R9: written ones appear in the enables after a set
   p_en_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      en_set_we |=> ((en_q & $past(wdata)) == $past(wdata)));

   // R9: written ones are gone from the enables after a clear
   p_en_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      en_clr_we |=> ((en_q & $past(wdata)) == '0));

   // R7: without a clear write no raw bit is lost
   p_raw_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_clr_we |=> ((raw_q & $past(raw_q)) == $past(raw_q)));

endmodule

// File: rtl/gpio_evt_ctrl.sv
module gpio_evt_ctrl #(
   parameter int unsigned NUM_PINS = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                dir_we,
   input  logic                dout_we,
   input  logic                oset_we,
   input  logic                oclr_we,
   input  logic                mlo_we,
   input  logic                mhi_we,
   input  logic                mrise_we,
   input  logic                mfall_we,
   input  logic [NUM_PINS-1:0] wdata,
   output logic [NUM_PINS-1:0] dir_q,
   output logic [NUM_PINS-1:0] latch_q,
   output logic [NUM_PINS-1:0] mlo_q,
   output logic [NUM_PINS-1:0] mhi_q,
   output logic [NUM_PINS-1:0] mrise_q,
   output logic [NUM_PINS-1:0] mfall_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dir_q <= '1;
      else if (dir_we) dir_q <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       latch_q <= '0;
      else if (dout_we) latch_q <= wdata;
      else if (oset_we) latch_q <= latch_q | wdata;
      else if (oclr_we) latch_q <= latch_q & ~wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mlo_q   <= '0;
         mhi_q   <= '0;
         mrise_q <= '0;
         mfall_q <= '0;
      end else begin
         if (mlo_we)   mlo_q   <= wdata;
         if (mhi_we)   mhi_q   <= wdata;
         if (mrise_we) mrise_q <= wdata;
         if (mfall_we) mfall_q <= wdata;
      end
   end

   // R3: a set write leaves every written one high in the latch
   p_out_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      oset_we |=> ((latch_q & $past(wdata)) == $past(wdata)));

   // R3: a clear write leaves every written one low, other bits kept
   p_out_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      oclr_we |=> ((latch_q & $past(wdata)) == '0 &&
                   (latch_q & ~$past(wdata)) == ($past(latch_q) & ~$past(wdata))));

   // R3: no latch write, no latch change
   p_out_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(dout_we || oset_we || oclr_we) |=> $stable(latch_q));

endmodule

// File: rtl/gpio_evt_bank.sv
module gpio_evt_bank
   import gpio_evt_pkg::*;
#(
   parameter int unsigned NUM_PINS    = 32,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned IRQ_LINES   = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_valid,
   input  logic                 bus_write,
   input  logic [GE_ADDR_W-1:0] bus_addr,
   input  logic [GE_DATA_W-1:0] bus_wdata,
   output logic [GE_DATA_W-1:0] bus_rdata,
   input  logic [NUM_PINS-1:0]  pin_in,
   output logic [NUM_PINS-1:0]  pin_out,
   output logic [NUM_PINS-1:0]  pin_drive_n,
   output logic [IRQ_LINES-1:0] irq_out
);

   generate
      if (NUM_PINS < 1 || NUM_PINS > GE_DATA_W) begin : g_bad_pins
         $error("gpio_evt_bank: NUM_PINS must be 1 to 32");
      end
      if (IRQ_LINES < 1 || IRQ_LINES > GE_MAX_LINES) begin : g_bad_lines
         $error("gpio_evt_bank: IRQ_LINES must be 1 or 2");
      end
   endgenerate

   reg_dec_t            dec;
   logic                wr;
   logic                rd;
   logic [NUM_PINS-1:0] wd;

   logic [NUM_PINS-1:0] dir_q, latch_q, mlo_q, mhi_q, mrise_q, mfall_q;
   logic [NUM_PINS-1:0] level_q, event_vec;

   logic [GE_MAX_LINES-1:0][NUM_PINS-1:0] raw_all;
   logic [GE_MAX_LINES-1:0][NUM_PINS-1:0] en_all;
   logic [GE_MAX_LINES-1:0]               irq_all;

   assign dec = ge_decode(bus_addr);
   assign wr  = bus_valid &  bus_write;
   assign rd  = bus_valid & ~bus_write;
   assign wd  = bus_wdata[NUM_PINS-1:0];

   gpio_evt_ctrl #(.NUM_PINS(NUM_PINS)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .dir_we   (wr && dec.sel == SEL_DIR),
      .dout_we  (wr && dec.sel == SEL_DOUT),
      .oset_we  (wr && dec.sel == SEL_OSET),
      .oclr_we  (wr && dec.sel == SEL_OCLR),
      .mlo_we   (wr && dec.sel == SEL_MLO),
      .mhi_we   (wr && dec.sel == SEL_MHI),
      .mrise_we (wr && dec.sel == SEL_MRISE),
      .mfall_we (wr && dec.sel == SEL_MFALL),
      .wdata    (wd),
      .dir_q    (dir_q),
      .latch_q  (latch_q),
      .mlo_q    (mlo_q),
      .mhi_q    (mhi_q),
      .mrise_q  (mrise_q),
      .mfall_q  (mfall_q)
   );

   gpio_evt_sampler #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_sampler (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_in    (pin_in),
      .mask_lo   (mlo_q),
      .mask_hi   (mhi_q),
      .mask_rise (mrise_q),
      .mask_fall (mfall_q),
      .level_q   (level_q),
      .event_vec (event_vec)
   );

   generate
      for (genvar l = 0; l < GE_MAX_LINES; l++) begin : g_line
         if (l < IRQ_LINES) begin : g_used
            gpio_evt_line #(.NUM_PINS(NUM_PINS)) u_line (
               .clk         (clk),
               .rst_n       (rst_n),
               .event_vec   (event_vec),
               .en_set_we   (wr && dec.sel == SEL_ENSET && dec.line == 1'(l)),
               .en_clr_we   (wr && dec.sel == SEL_ENCLR && dec.line == 1'(l)),
               .stat_clr_we (wr && dec.sel == SEL_STAT  && dec.line == 1'(l)),
               .wdata       (wd),
               .raw_q       (raw_all[l]),
               .en_q        (en_all[l]),
               .irq         (irq_all[l])
            );
         end else begin : g_absent
            assign raw_all[l] = '0;
            assign en_all[l]  = '0;
            assign irq_all[l] = 1'b0;
         end
      end
   endgenerate

   function automatic logic [GE_DATA_W-1:0] widen(input logic [NUM_PINS-1:0] v);
      logic [GE_DATA_W-1:0] w;
      w = '0;
      w[NUM_PINS-1:0] = v;
      return w;
   endfunction

   always_comb begin
      bus_rdata = '0;
      if (rd) begin
         case (dec.sel)
            SEL_REV:   bus_rdata = GE_REVISION;
            SEL_RAW:   bus_rdata = widen(raw_all[dec.line]);
            SEL_STAT:  bus_rdata = widen(raw_all[dec.line] & en_all[dec.line]);
            SEL_ENSET,
            SEL_ENCLR: bus_rdata = widen(en_all[dec.line]);
            SEL_DIR:   bus_rdata = widen(dir_q);
            SEL_DIN:   bus_rdata = widen(level_q);
            SEL_DOUT:  bus_rdata = widen(latch_q);
            SEL_MLO:   bus_rdata = widen(mlo_q);
            SEL_MHI:   bus_rdata = widen(mhi_q);
            SEL_MRISE: bus_rdata = widen(mrise_q);
            SEL_MFALL: bus_rdata = widen(mfall_q);
            default:   bus_rdata = '0;
         endcase
      end
   end

   assign pin_out     = latch_q;
   assign pin_drive_n = dir_q;
   assign irq_out     = irq_all[IRQ_LINES-1:0];

   // R2: a direction write shows on the pad enables in the next cycle
   p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && dec.sel == SEL_DIR) |=> (pin_drive_n == $past(wd)));

endmodule

// File: tb/gpio_evt_bank_bench.sv
module gpio_evt_bank_bench;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] pin_in = '0;
   logic [31:0] pin_out;
   logic [31:0] pin_drive_n;
   logic [1:0]  irq_out;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   logic [31:0] cur_pins = '0;

   // behavioural reference state
   logic [31:0] m_s1, m_s2, m_prev, m_latch, m_oe;
   logic [31:0] m_lo, m_hi, m_ri, m_fa;
   logic [31:0] m_en[2];
   logic [31:0] m_raw[2];

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_evt_bank u_gpio_evt_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_valid   (bus_valid),
      .bus_write   (bus_write),
      .bus_addr    (bus_addr),
      .bus_wdata   (bus_wdata),
      .bus_rdata   (bus_rdata),
      .pin_in      (pin_in),
      .pin_out     (pin_out),
      .pin_drive_n (pin_drive_n),
      .irq_out     (irq_out)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic string req_of(input logic [11:0] a);
      case (a)
         12'h000: return "R11";
         12'h024, 12'h028: return "R7";
         12'h02C, 12'h030: return "R8";
         12'h034, 12'h038, 12'h03C, 12'h040: return "R9";
         12'h134: return "R2";
         12'h138: return "R4";
         12'h13C: return "R3";
         12'h140, 12'h144: return "R5";
         12'h148, 12'h14C: return "R6";
         default: return "R11";
      endcase
   endfunction

   function automatic logic [31:0] model_rdata();
      if (!(bus_valid && !bus_write)) return 32'h0;
      case (bus_addr)
         12'h000: return 32'h5060_0801;
         12'h024: return m_raw[0];
         12'h028: return m_raw[1];
         12'h02C: return m_raw[0] & m_en[0];
         12'h030: return m_raw[1] & m_en[1];
         12'h034, 12'h03C: return m_en[0];
         12'h038, 12'h040: return m_en[1];
         12'h134: return m_oe;
         12'h138: return m_s2;
         12'h13C: return m_latch;
         12'h140: return m_lo;
         12'h144: return m_hi;
         12'h148: return m_ri;
         12'h14C: return m_fa;
         default: return 32'h0;
      endcase
   endfunction

   task automatic model_reset();
      m_s1 = '0; m_s2 = '0; m_prev = '0; m_latch = '0; m_oe = '1;
      m_lo = '0; m_hi = '0; m_ri = '0; m_fa = '0;
      m_en[0] = '0; m_en[1] = '0; m_raw[0] = '0; m_raw[1] = '0;
   endtask

   task automatic model_step();
      logic [31:0] evt;
      logic        w;
      evt = (~m_s2 & m_lo) | (m_s2 & m_hi) | (m_s2 & ~m_prev & m_ri) | (~m_s2 & m_prev & m_fa);
      w   = bus_valid && bus_write;
      m_raw[0] = (m_raw[0] & ~((w && bus_addr == 12'h02C) ? bus_wdata : 32'h0)) | evt;
      m_raw[1] = (m_raw[1] & ~((w && bus_addr == 12'h030) ? bus_wdata : 32'h0)) | evt;
      if (w) begin
         case (bus_addr)
            12'h034: m_en[0] = m_en[0] | bus_wdata;
            12'h038: m_en[1] = m_en[1] | bus_wdata;
            12'h03C: m_en[0] = m_en[0] & ~bus_wdata;
            12'h040: m_en[1] = m_en[1] & ~bus_wdata;
            12'h134: m_oe = bus_wdata;
            12'h13C: m_latch = bus_wdata;
            12'h194: m_latch = m_latch | bus_wdata;
            12'h190: m_latch = m_latch & ~bus_wdata;
            12'h140: m_lo = bus_wdata;
            12'h144: m_hi = bus_wdata;
            12'h148: m_ri = bus_wdata;
            12'h14C: m_fa = bus_wdata;
            default: ;
         endcase
      end
      m_prev = m_s2;
      m_s2   = m_s1;
      m_s1   = pin_in;
   endtask

   // one bus cycle: drive at the falling edge, compare, clock the model
   task automatic cyc(input logic v, input logic w, input logic [11:0] a,
                      input logic [31:0] d, input logic lit_en,
                      input logic [31:0] lit, input string lit_req);
      bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d; pin_in = cur_pins;
      #1;
      chk("R3", "pin_out", pin_out, m_latch);
      chk("R2", "pin_drive_n", pin_drive_n, m_oe);
      chk("R10", "irq_out", {30'h0, irq_out},
          {30'h0, |(m_raw[1] & m_en[1]), |(m_raw[0] & m_en[0])});
      chk(req_of(a), "bus_rdata", bus_rdata, model_rdata());
      if (lit_en) chk(lit_req, "directed read", bus_rdata, lit);
      @(posedge clk);
      model_step();
      @(negedge clk);
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      cyc(1'b1, 1'b1, a, d, 1'b0, 32'h0, "");
   endtask

   task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string req);
      cyc(1'b1, 1'b0, a, 32'h0, 1'b1, exp, req);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 12'h000, 32'h0, 1'b0, 32'h0, "");
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired, actual=running expected=finished");
         report();
         $finish;
      end
   end

   initial begin
      logic [11:0] addrs [20];
      addrs = '{12'h000, 12'h024, 12'h028, 12'h02C, 12'h030, 12'h034, 12'h038,
                12'h03C, 12'h040, 12'h134, 12'h138, 12'h13C, 12'h140, 12'h144,
                12'h148, 12'h14C, 12'h190, 12'h194, 12'h200, 12'h130};
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset values at the pads and interrupt outputs
      chk("R1", "pin_drive_n in reset", pin_drive_n, 32'hFFFF_FFFF);
      chk("R1", "pin_out in reset", pin_out, 32'h0);
      chk("R1", "irq_out in reset", {30'h0, irq_out}, 32'h0);
      rst_n = 1'b1;

      // R1: register reset values
      rd(12'h134, 32'hFFFF_FFFF, "R1");
      rd(12'h13C, 32'h0, "R1");
      rd(12'h140, 32'h0, "R1");
      rd(12'h148, 32'h0, "R1");
      rd(12'h034, 32'h0, "R1");
      rd(12'h040, 32'h0, "R1");
      rd(12'h024, 32'h0, "R1");
      rd(12'h000, 32'h5060_0801, "R11");

      // R2 direction, R3 latch aliases
      wr(12'h134, 32'hFFFF_0000);
      rd(12'h134, 32'hFFFF_0000, "R2");
      chk("R2", "pin_drive_n after write", pin_drive_n, 32'hFFFF_0000);
      wr(12'h13C, 32'h1234_5678);
      wr(12'h194, 32'h0000_F00F);
      rd(12'h13C, 32'h1234_F67F, "R3");
      wr(12'h190, 32'h1234_0000);
      rd(12'h13C, 32'h0000_F67F, "R3");
      wr(12'h194, 32'h0);
      wr(12'h190, 32'h0);
      chk("R3", "latch after zero writes", pin_out, 32'h0000_F67F);

      // R4 synchronized input
      cur_pins = 32'hA5A5_A5A5;
      idle(2);
      rd(12'h138, 32'hA5A5_A5A5, "R4");

      // R5 level detection
      cur_pins = 32'h0000_0020;
      idle(3);
      wr(12'h140, 32'h0000_0008);
      wr(12'h144, 32'h0000_0020);
      idle(2);
      rd(12'h024, 32'h0000_0028, "R7");
      rd(12'h028, 32'h0000_0028, "R7");
      chk("R10", "irq before enable", {30'h0, irq_out}, 32'h0);
      wr(12'h034, 32'h0000_0020);
      chk("R10", "irq line 0 only", {30'h0, irq_out}, 32'h1);
      rd(12'h02C, 32'h0000_0020, "R8");
      wr(12'h02C, 32'h0000_0020);
      rd(12'h024, 32'h0000_0028, "R5");
      wr(12'h02C, 32'h0);
      rd(12'h024, 32'h0000_0028, "R8");
      cur_pins = 32'h0000_0028;
      idle(3);
      wr(12'h030, 32'h0000_0008);
      idle(1);
      rd(12'h028, 32'h0000_0020, "R8");
      rd(12'h024, 32'h0000_0028, "R8");
      wr(12'h140, 32'h0);
      wr(12'h144, 32'h0);
      wr(12'h02C, 32'hFFFF_FFFF);
      wr(12'h030, 32'hFFFF_FFFF);
      rd(12'h024, 32'h0, "R8");
      rd(12'h028, 32'h0, "R8");

      // R9 enable set/clear
      wr(12'h03C, 32'h0000_0020);
      rd(12'h034, 32'h0, "R9");
      wr(12'h038, 32'h0000_0001);
      wr(12'h040, 32'h0);
      rd(12'h040, 32'h0000_0001, "R9");
      wr(12'h040, 32'h0000_0001);
      rd(12'h038, 32'h0, "R9");

      // R6 edge detection
      wr(12'h148, 32'h0000_0500);
      wr(12'h14C, 32'h0000_0600);
      cur_pins = 32'h0000_0528;
      idle(4);
      rd(12'h024, 32'h0000_0500, "R6");
      wr(12'h02C, 32'h0000_0500);
      idle(3);
      rd(12'h024, 32'h0, "R6");
      cur_pins = 32'h0000_0028;
      idle(4);
      rd(12'h024, 32'h0000_0400, "R6");
      cur_pins = 32'h0000_0228;
      idle(4);
      cur_pins = 32'h0000_0028;
      idle(4);
      rd(12'h024, 32'h0000_0600, "R6");
      rd(12'h028, 32'h0000_0700, "R6");

      // R11 revision and holes
      wr(12'h000, 32'h0);
      rd(12'h000, 32'h5060_0801, "R11");
      rd(12'h200, 32'h0, "R11");
      wr(12'h194, 32'h1);
      rd(12'h194, 32'h0, "R11");
      rd(12'h190, 32'h0, "R11");

      // mixed random traffic against the model
      for (int i = 0; i < 6000; i++) begin
         logic [31:0] d;
         int          pick;
         if ($urandom_range(0, 3) == 0) cur_pins = cur_pins ^ (32'h1 << $urandom_range(0, 31));
         if ($urandom_range(0, 15) == 0) cur_pins = $urandom;
         pick = $urandom_range(0, 19);
         d    = ($urandom_range(0, 1) == 0) ? $urandom : (32'h1 << $urandom_range(0, 31));
         case ($urandom_range(0, 2))
            0: wr(addrs[pick], d);
            1: cyc(1'b1, 1'b0, addrs[pick], 32'h0, 1'b0, 32'h0, "");
            default: idle(1);
         endcase
      end

      done = 1'b1;
      report();
      $finish;
   end

endmodule